// File: doc/BRIEF.md
# Dual 16-bit SIMD multiply-accumulate unit

This execution unit accepts a 32-bit instruction word with a valid qualifier and performs two signed 16x16 multiplies in parallel. The word names two source registers, two accumulator registers, an operand pattern and an accumulate pattern. The operand pattern selects which halves of the sources are paired into a left and a right product. The accumulate pattern decides, for each lane separately, whether the product is added to or subtracted from its accumulator. Both results are written back into a small internal file of sixteen 32-bit registers through two write ports.

A test port writes and reads any register by index, so operands can be preloaded and results read back. The unit gives a single-cycle done strobe one clock after it accepts an instruction. By then both results are already stored.

Top module: `dmac_unit`

## Requirements
- R1: Instruction fields: first accumulator index = bits [9:6], first source (B) = [13:10], second source (C) = [17:14], second accumulator index = [21:18], operand pattern = [23:22], accumulate pattern = [25:24]. All other bits are ignored.
- R2: Each source register is split into a high half [31:16] and a low half [15:0]. Each half is treated as a signed 16-bit value.
- R3: Operand pattern 0 gives left = B.high*C.high and right = B.low*C.low. Pattern 1 gives left = B.low*C.high and right = B.low*C.low. Pattern 2 gives left = B.high*C.high and right = B.high*C.low. Pattern 3 gives left = B.low*C.high and right = B.high*C.low.
- R4: Accumulate pattern 0 adds both products. Pattern 1 adds left and subtracts right. Pattern 2 subtracts left and adds right. Pattern 3 subtracts both. A subtraction is accumulator minus product.
- R5: Register 0 always reads as zero, and any write to it is ignored.
- R6: The left result (old first accumulator ± left product) is written to the first accumulator register.
- R7: The right result (old second accumulator ± right product) is written to the second accumulator register. When both accumulator indices are equal, the right result is the one kept.
- R8: Arithmetic is 32-bit two's complement and wraps on overflow, with no saturation.
- R9: done_o is high for exactly the one cycle after each accepted instruction. The results can be read in that cycle.
- R10: The test port reads any register combinationally and writes it on a clock edge when tst_we_i is high. A test write in a cycle that also has instr_valid_i high is ignored.
- R11: Reset (rst_ni low) clears every register and done_o.
- R12: Every operand and accumulator is read before either write. An instruction whose destination is also a source uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| done_o | output | 1 | Pulse one cycle after an accepted instruction |
| tst_we_i | input | 1 | Test port write enable |
| tst_idx_i | input | 4 | Test port register index |
| tst_wdata_i | input | 32 | Test port write data |
| tst_rdata_o | output | 32 | Test port read data (combinational) |

## Verification
An instruction presented before a rising edge stores both results at that edge, and done_o is high for the following cycle. The bench drives each instruction at a falling edge and samples done_o at the next falling edge. In that same half cycle it reads both destinations through the combinational test port, then checks one cycle later that done_o has dropped. Test-port writes take effect at the next edge and are read back at the falling edge after it. Expected values come from a bench model that reads all old register values before it applies either write.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW    = 32;
  localparam int HW    = 16;
  localparam int IDX_W = 4;
  localparam int NREG  = 1 << IDX_W;

  // field positions fixed by the instruction encoding
  localparam int ACC_A_LSB = 6;
  localparam int SRC_B_LSB = 10;
  localparam int SRC_C_LSB = 14;
  localparam int ACC_D_LSB = 18;
  localparam int OPAT_LSB  = 22;
  localparam int APAT_LSB  = 24;

  typedef struct packed {
    logic [IDX_W-1:0] acc_a;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] src_c;
    logic [IDX_W-1:0] acc_d;
    logic [1:0]       opat;
    logic [1:0]       apat;
  } dmac_fields_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [DW-1:0]  instr_i,
  output dmac_fields_t   fld_o
);
  always_comb begin
    fld_o.acc_a = instr_i[ACC_A_LSB +: IDX_W];
    fld_o.src_b = instr_i[SRC_B_LSB +: IDX_W];
    fld_o.src_c = instr_i[SRC_C_LSB +: IDX_W];
    fld_o.acc_d = instr_i[ACC_D_LSB +: IDX_W];
    fld_o.opat  = instr_i[OPAT_LSB +: 2];
    fld_o.apat  = instr_i[APAT_LSB +: 2];
  end
endmodule

// File: rtl/dmac_lane.sv
module dmac_lane #(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  logic signed [HW-1:0] a_i,
  input  logic signed [HW-1:0] b_i,
  input  logic        [DW-1:0] acc_i,
  input  logic                 sub_i,
  output logic        [DW-1:0] res_o
);
  logic signed [2*HW-1:0] prod;
  logic signed [DW-1:0]   prod_ext;

  assign prod     = a_i * b_i;
  assign prod_ext = DW'(prod);
  assign res_o    = sub_i ? acc_i - prod_ext : acc_i + prod_ext;
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i [4],
  output logic [DW-1:0]    ra_data_o [4],
  input  logic             we_a_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [DW-1:0]    data_a_i,
  input  logic             we_b_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  logic [DW-1:0]    data_b_i,
  input  logic             tst_we_i,
  input  logic [IDX_W-1:0] tst_idx_i,
  input  logic [DW-1:0]    tst_wdata_i,
  output logic [DW-1:0]    tst_rdata_o
);
  localparam int NREG = 1 << IDX_W;

  logic [DW-1:0] mem [NREG];

  for (genvar p = 0; p < 4; p++) begin : g_rd
    assign ra_data_o[p] = (ra_idx_i[p] == '0) ? '0 : mem[ra_idx_i[p]];
  end
  assign tst_rdata_o = (tst_idx_i == '0) ? '0 : mem[tst_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_a_i || we_b_i) begin
      if (we_a_i && idx_a_i != '0) mem[idx_a_i] <= data_a_i;
      // port b last: it wins on equal index
      if (we_b_i && idx_b_i != '0) mem[idx_b_i] <= data_b_i;
    end else if (tst_we_i && tst_idx_i != '0) begin
      mem[tst_idx_i] <= tst_wdata_i;
    end
  end

  // R6: left write lands unless overridden by port b
  p_wr_left_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_a_i && idx_a_i != '0 && !(we_b_i && idx_b_i == idx_a_i)
    |=> mem[$past(idx_a_i)] == $past(data_a_i));

  // R7: right write always lands
  p_wr_right_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_b_i && idx_b_i != '0 |=> mem[$past(idx_b_i)] == $past(data_b_i));

  // R10: test write blocked while an instruction writes
  p_tst_blocked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_we_i && we_a_i && we_b_i && tst_idx_i != idx_a_i && tst_idx_i != idx_b_i
    |=> mem[$past(tst_idx_i)] == $past(mem[tst_idx_i]));
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [DW-1:0]    instr_i,
  output logic             done_o,
  input  logic             tst_we_i,
  input  logic [IDX_W-1:0] tst_idx_i,
  input  logic [DW-1:0]    tst_wdata_i,
  output logic [DW-1:0]    tst_rdata_o
);
  dmac_fields_t     fld;
  logic [IDX_W-1:0] rd_idx [4];
  logic [DW-1:0]    rd_data [4];
  logic [DW-1:0]    src_b, src_c, acc_a, acc_d;
  logic [HW-1:0]    lane_a [2];
  logic [HW-1:0]    lane_b [2];
  logic [DW-1:0]    lane_acc [2];
  logic             lane_sub [2];
  logic [DW-1:0]    lane_res [2];
  logic             done_q;

  dmac_decode u_dec (.instr_i(instr_i), .fld_o(fld));

  assign rd_idx[0] = fld.src_b;
  assign rd_idx[1] = fld.src_c;
  assign rd_idx[2] = fld.acc_a;
  assign rd_idx[3] = fld.acc_d;
  assign src_b = rd_data[0];
  assign src_c = rd_data[1];
  assign acc_a = rd_data[2];
  assign acc_d = rd_data[3];

  // lane 0 = left (C.high), lane 1 = right (C.low)
  assign lane_a[0]   = fld.opat[0] ? src_b[HW-1:0] : src_b[DW-1:HW];
  assign lane_b[0]   = src_c[DW-1:HW];
  assign lane_acc[0] = acc_a;
  assign lane_sub[0] = fld.apat[1];
  assign lane_a[1]   = fld.opat[1] ? src_b[DW-1:HW] : src_b[HW-1:0];
  assign lane_b[1]   = src_c[HW-1:0];
  assign lane_acc[1] = acc_d;
  assign lane_sub[1] = fld.apat[0];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    dmac_lane #(.DW(DW), .HW(HW)) u_lane (
      .a_i   (lane_a[l]),
      .b_i   (lane_b[l]),
      .acc_i (lane_acc[l]),
      .sub_i (lane_sub[l]),
      .res_o (lane_res[l])
    );
  end

  dmac_regfile #(.DW(DW), .IDX_W(IDX_W)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ra_idx_i    (rd_idx),
    .ra_data_o   (rd_data),
    .we_a_i      (instr_valid_i),
    .idx_a_i     (fld.acc_a),
    .data_a_i    (lane_res[0]),
    .we_b_i      (instr_valid_i),
    .idx_b_i     (fld.acc_d),
    .data_b_i    (lane_res[1]),
    .tst_we_i    (tst_we_i),
    .tst_idx_i   (tst_idx_i),
    .tst_wdata_i (tst_wdata_i),
    .tst_rdata_o (tst_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= instr_valid_i;
  end
  assign done_o = done_q;

  // R9: done follows each accepted instruction
  p_done_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> done_o);

  // R5: index 0 reads zero at the test port
  p_zero_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_idx_i == '0 |-> tst_rdata_o == '0);
endmodule

// File: tb/tb_dmac_unit.sv
`timescale 1ns/1ps
module tb_dmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic        done;
  logic        tst_we = 1'b0;
  logic [3:0]  tst_idx = '0;
  logic [31:0] tst_wdata = '0;
  logic [31:0] tst_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  dmac_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .done_o(done), .tst_we_i(tst_we), .tst_idx_i(tst_idx),
    .tst_wdata_i(tst_wdata), .tst_rdata_o(tst_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    tst_idx = idx;
    #0.5;
    v = tst_rdata;
  endtask

  task automatic chk_reg(string req, logic [3:0] idx);
    logic [31:0] v;
    rd(idx, v);
    chk(req, v, model[idx]);
  endtask

  task automatic preload(logic [3:0] idx, logic [31:0] val);
    @(negedge clk);
    tst_we = 1'b1; tst_idx = idx; tst_wdata = val;
    @(negedge clk);
    tst_we = 1'b0;
    if (idx != 0) model[idx] = val;
  endtask

  function automatic logic [31:0] sx(logic [15:0] h);
    return {{16{h[15]}}, h};
  endfunction

  task automatic exec(logic [3:0] xa, logic [3:0] xb, logic [3:0] xc,
                      logic [3:0] xd, logic [1:0] op, logic [1:0] ap);
    logic [31:0] b, c, a, d, lp, rp, rl, rr;
    b = model[xb]; c = model[xc]; a = model[xa]; d = model[xd];
    case (op)
      2'd0: begin lp = sx(b[31:16]) * sx(c[31:16]); rp = sx(b[15:0]) * sx(c[15:0]); end
      2'd1: begin lp = sx(b[15:0]) * sx(c[31:16]);  rp = sx(b[15:0]) * sx(c[15:0]); end
      2'd2: begin lp = sx(b[31:16]) * sx(c[31:16]); rp = sx(b[31:16]) * sx(c[15:0]); end
      default: begin lp = sx(b[15:0]) * sx(c[31:16]); rp = sx(b[31:16]) * sx(c[15:0]); end
    endcase
    case (ap)
      2'd0: begin rl = a + lp; rr = d + rp; end
      2'd1: begin rl = a + lp; rr = d - rp; end
      2'd2: begin rl = a - lp; rr = d + rp; end
      default: begin rl = a - lp; rr = d - rp; end
    endcase
    if (xa != 0) model[xa] = rl;
    if (xd != 0) model[xd] = rr;
    @(negedge clk);
    valid = 1'b1;
    instr = {6'b101001, ap, op, xd, xc, xb, xa, 6'b110011}; // R1 junk in unused bits
    @(negedge clk);
    valid = 1'b0;
    chk("R9 done", {31'b0, done}, 32'd1);
    chk_reg("R6 left", xa);
    chk_reg("R7 right", xd);
    @(negedge clk);
    chk("R9 done drop", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) model[i] = '0;
    for (int i = 0; i < 16; i++) chk_reg("R11 reset", i[3:0]);
    chk("R11 done reset", {31'b0, done}, 32'd0);
  endtask

  task automatic t_preload;
    preload(4'd3, 32'hDEAD_BEEF);
    preload(4'd15, 32'h1234_5678);
    preload(4'd0, 32'hFFFF_FFFF);
    chk_reg("R10 tst rw", 4'd3);
    chk_reg("R10 tst rw", 4'd15);
    chk_reg("R5 zero reg", 4'd0);
  endtask

  task automatic t_patterns;
    for (int op = 0; op < 4; op++)
      for (int ap = 0; ap < 4; ap++) begin
        preload(4'd1, 32'h8003_FFFB);  // high=-32765 low=-5
        preload(4'd2, 32'h0007_C001);  // high=7 low=-16383
        preload(4'd4, 32'h0000_1000);
        preload(4'd5, 32'hFFFF_0000);
        exec(4'd4, 4'd1, 4'd2, 4'd5, op[1:0], ap[1:0]); // R3 R4 R2
      end
  endtask

  task automatic t_wrap;
    preload(4'd6, 32'h7FFF_8000);
    preload(4'd7, 32'h7FFF_8000);
    preload(4'd8, 32'h7FFF_FFFF);
    preload(4'd9, 32'h8000_0000);
    exec(4'd8, 4'd6, 4'd7, 4'd9, 2'd0, 2'd1); // R8
    chk("R8 wrap", model[8], 32'h7FFF_FFFF + 32'h3FFF_0001);
  endtask

  task automatic t_same_dst;
    preload(4'd10, 32'h0002_0003);
    preload(4'd11, 32'h0004_0005);
    preload(4'd12, 32'h0000_0100);
    exec(4'd12, 4'd10, 4'd11, 4'd12, 2'd0, 2'd0); // R7 right wins
    chk("R7 same dst", model[12], 32'h0000_010F);
  endtask

  task automatic t_dst_zero;
    preload(4'd1, 32'h0003_0003);
    exec(4'd0, 4'd1, 4'd1, 4'd0, 2'd0, 2'd0);
    chk_reg("R5 dst zero", 4'd0);
  endtask

  task automatic t_overlap;
    preload(4'd13, 32'h0002_0003);
    preload(4'd14, 32'h0010_0020);
    exec(4'd13, 4'd13, 4'd13, 4'd14, 2'd0, 2'd0); // R12
    chk("R12 old values", model[13], 32'h0002_0007);
  endtask

  task automatic t_tst_blocked;
    logic [31:0] v;
    preload(4'd5, 32'hA5A5_0000);
    preload(4'd1, 32'h0001_0001);
    preload(4'd2, 32'h0001_0001);
    model[3] = 32'h0;
    preload(4'd3, 32'h0);
    model[4] = 32'h0;
    preload(4'd4, 32'h0);
    @(negedge clk);
    valid = 1'b1;
    instr = {6'b0, 2'd0, 2'd0, 4'd4, 4'd2, 4'd1, 4'd3, 6'b0};
    tst_we = 1'b1; tst_idx = 4'd5; tst_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    valid = 1'b0; tst_we = 1'b0;
    rd(4'd5, v);
    chk("R10 blocked", v, 32'hA5A5_0000);
    rd(4'd3, v);
    chk("R6 with tst", v, 32'h1);
  endtask

  task automatic t_midreset;
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(4'd15, v);
    chk("R11 async reset", v, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #50000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_preload();
    t_patterns();
    t_wrap();
    t_same_dst();
    t_dst_zero();
    t_overlap();
    t_tst_blocked();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule